// File: doc/BRIEF.md
# Remap register write-lock controller

This block protects a bank of pin-remapping control registers from accidental change. A single lock bit gates every write to those registers. The lock bit can only be changed by a keyed sequence on the oscillator-control register: the byte 0x46, then the byte 0x57, then one more write to the same register that carries the new lock value in bit 6. After one unlock, software may update the remap registers as often as it likes until it locks them again. When a one-way configuration input is active, the lock cannot be cleared once it has been set. Only a reset makes the bank writable again.

The live remap registers sit in an external register file. This block tells that file which register to load, through a one-hot write enable that the block produces in the same cycle as the bus write. The block also keeps a shadow copy of every protected register and compares it with the live contents on every cycle. If a live register differs from its shadow without an allowed write having caused the change, for example after a cell upset, the block raises a one-cycle configuration-mismatch reset request for the reset generator.

Top module: `remap_lock_ctrl`

## Requirements
- R1: While lock_o is 1, a bus write to a remap address (REMAP_BASE to REMAP_BASE+NREG-1, default 4..7) completes, but regfile_we_o stays all zero and the register contents do not change.
- R2: While lock_o is 0, a bus write to remap address REMAP_BASE+i drives regfile_we_o to the one-hot value 1<<i in the same cycle. A write to any other address drives no enable.
- R3: lock_o changes only on the write to OSC_ADDR (default 0) that follows a write of 0x46 and then a write of 0x57 to wdata[7:0] at OSC_ADDR. The new value is wdata[6] of that third write, and the other bits are ignored. The key writes themselves and unkeyed writes to OSC_ADDR leave lock_o unchanged.
- R4: lock_o holds its value until it is changed explicitly, so a single unlock permits any number of remap writes.
- R5: When one_way_i is 1 and lock_o has been set since the last reset, an attempt to clear it is ignored. When one_way_i is 0, a keyed sequence can clear the lock again.
- R6: Cycles without a write do not affect the key sequence. A wrong key value, or any other bus write between the keyed writes, returns the sequencer to idle, and the write that follows does not change lock_o.
- R7: Reset clears lock_o, the sequencer, the one-way history and the shadows, and holds mismatch_rst_o at 0.
- R8: If live_regs_i differs from the shadow copies, mismatch_rst_o goes to 1 for exactly one cycle, in the cycle after the first clock edge at which the difference is present.
- R9: An allowed remap write loads the live register and its shadow at the same edge, so it never raises mismatch_rst_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | AW | Bus write address |
| bus_wdata_i | input | DW | Bus write data |
| one_way_i | input | 1 | One-way lock configuration, 1 = active (unprogrammed default) |
| live_regs_i | input | NREG*DW | Live remap register contents, register i at bits [i*DW +: DW] |
| regfile_we_o | output | NREG | One-hot write enable to the remap register file |
| lock_o | output | 1 | Current lock bit, 1 = remap writes blocked |
| mismatch_rst_o | output | 1 | One-cycle configuration-mismatch reset request |

## Verification
The hardest condition to reach is a shadow mismatch, because no legal bus traffic can cause one. The bench therefore models the register file itself and applies an XOR fault mask to the live contents it feeds back. Every bit of every register is flipped in turn, and the bench checks that the request pulse appears in the right cycle and lasts exactly one cycle. The key sequencer is swept over all 256 values of the first key and all 256 values of the second key, with intervening writes in between, to show that only the exact keyed sequence moves the lock.

// File: rtl/remap_lock_pkg.sv
package remap_lock_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_KEY1  = 2'd1,
    SEQ_ARMED = 2'd2
  } seq_state_e;

  localparam logic [7:0] KEY_FIRST  = 8'h46;
  localparam logic [7:0] KEY_SECOND = 8'h57;
  localparam int unsigned LOCK_POS  = 6;
endpackage

// File: rtl/unlock_seq.sv
module unlock_seq
  import remap_lock_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       any_wr_i,
  input  logic       osc_wr_i,
  input  logic [7:0] wbyte_i,
  input  logic       one_way_i,
  output logic       lock_o
);
  seq_state_e state_q, state_d;
  logic lock_q, lock_d;
  logic set_once_q, set_once_d;
  logic upd;

  always_comb begin
    state_d = state_q;
    if (any_wr_i) begin
      unique case (state_q)
        SEQ_IDLE:  state_d = (osc_wr_i && wbyte_i == KEY_FIRST)  ? SEQ_KEY1  : SEQ_IDLE;
        SEQ_KEY1:  state_d = (osc_wr_i && wbyte_i == KEY_SECOND) ? SEQ_ARMED : SEQ_IDLE;
        default:   state_d = SEQ_IDLE;
      endcase
    end
  end

  assign upd = (state_q == SEQ_ARMED) && osc_wr_i;

  always_comb begin
    lock_d     = lock_q;
    set_once_d = set_once_q;
    if (upd) begin
      if (wbyte_i[LOCK_POS]) begin
        lock_d     = 1'b1;
        set_once_d = 1'b1;
      end else if (!(one_way_i && set_once_q)) begin
        lock_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_IDLE;
      lock_q     <= 1'b0;
      set_once_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      lock_q     <= lock_d;
      set_once_q <= set_once_d;
    end
  end

  assign lock_o = lock_q;

  assert_lock_keyed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lock_q) |-> $past(state_q == SEQ_ARMED && osc_wr_i));

  assert_one_way_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (one_way_i && set_once_q && lock_q) |=> lock_q);

  assert_bad_key_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_KEY1 && any_wr_i && !(osc_wr_i && wbyte_i == KEY_SECOND))
      |=> state_q == SEQ_IDLE);

  assert_lock_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_wr_i |=> $stable(lock_q));
endmodule

// File: rtl/write_gate.sv
module write_gate #(
  parameter int unsigned NREG       = 4,
  parameter int unsigned AW         = 4,
  parameter int unsigned REMAP_BASE = 4
) (
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          lock_i,
  output logic [NREG-1:0] we_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_dec
    localparam logic [AW-1:0] RegAddr = AW'(REMAP_BASE + g);
    assign we_o[g] = bus_we_i && (bus_addr_i == RegAddr) && !lock_i;
  end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank #(
  parameter int unsigned NREG = 4,
  parameter int unsigned DW   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NREG-1:0]    we_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [NREG*DW-1:0] live_i,
  output logic               rst_req_o
);
  logic [NREG-1:0] diff;
  logic diff_any, diff_seen_q, req_q;

  for (genvar g = 0; g < NREG; g++) begin : g_shadow
    logic [DW-1:0] shadow_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      shadow_q <= '0;
      else if (we_i[g]) shadow_q <= wdata_i;
    end
    assign diff[g] = shadow_q != live_i[g*DW +: DW];

    assert_shadow_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i[g] |=> shadow_q == $past(wdata_i));
  end

  assign diff_any = |diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diff_seen_q <= 1'b0;
      req_q       <= 1'b0;
    end else begin
      diff_seen_q <= diff_any;
      req_q       <= diff_any && !diff_seen_q;
    end
  end

  assign rst_req_o = req_q;

  assert_req_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);

  assert_req_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(diff_any));
endmodule

// File: rtl/remap_lock_ctrl.sv
module remap_lock_ctrl
  import remap_lock_pkg::*;
#(
  parameter int unsigned NREG       = 4,
  parameter int unsigned DW         = 16,
  parameter int unsigned AW         = 4,
  parameter int unsigned OSC_ADDR   = 0,
  parameter int unsigned REMAP_BASE = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  input  logic               one_way_i,
  input  logic [NREG*DW-1:0] live_regs_i,
  output logic [NREG-1:0]    regfile_we_o,
  output logic               lock_o,
  output logic               mismatch_rst_o
);
  localparam logic [AW-1:0] OscAddr = AW'(OSC_ADDR);

  logic osc_wr;
  logic lock;

  assign osc_wr = bus_we_i && (bus_addr_i == OscAddr);

  unlock_seq i_unlock_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .any_wr_i  (bus_we_i),
    .osc_wr_i  (osc_wr),
    .wbyte_i   (bus_wdata_i[7:0]),
    .one_way_i (one_way_i),
    .lock_o    (lock)
  );

  write_gate #(
    .NREG       (NREG),
    .AW         (AW),
    .REMAP_BASE (REMAP_BASE)
  ) i_write_gate (
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .lock_i     (lock),
    .we_o       (regfile_we_o)
  );

  shadow_bank #(
    .NREG (NREG),
    .DW   (DW)
  ) i_shadow_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (regfile_we_o),
    .wdata_i   (bus_wdata_i),
    .live_i    (live_regs_i),
    .rst_req_o (mismatch_rst_o)
  );

  assign lock_o = lock;

  assert_locked_no_we_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |-> regfile_we_o == '0);

  assert_we_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(regfile_we_o));

  assert_we_needs_bus_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (regfile_we_o != '0) |-> bus_we_i);
endmodule

// File: tb/test_remap_lock_ctrl.sv
`timescale 1ns/1ps
module test_remap_lock_ctrl;
  localparam int NREG = 4;
  localparam int DW   = 16;
  localparam int AW   = 4;
  localparam int OSC  = 0;
  localparam int BASE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic one_way = 1'b0;
  logic [NREG*DW-1:0] live_flat;
  logic [NREG-1:0] regfile_we_o;
  logic lock_o, mismatch_rst_o;

  logic [DW-1:0] live_q [NREG];
  logic [DW-1:0] flip [NREG];
  logic [NREG-1:0] we_snap;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  remap_lock_ctrl #(.NREG(NREG), .DW(DW), .AW(AW), .OSC_ADDR(OSC), .REMAP_BASE(BASE))
  i_remap_lock_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .one_way_i(one_way), .live_regs_i(live_flat),
    .regfile_we_o(regfile_we_o), .lock_o(lock_o), .mismatch_rst_o(mismatch_rst_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) live_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) if (regfile_we_o[i]) live_q[i] <= bus_wdata;
    end
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) live_flat[i*DW +: DW] = live_q[i] ^ flip[i];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
    #1 we_snap = regfile_we_o;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic key_seq(input int k1, input int k2, input int v);
    bus_wr(OSC, k1); bus_wr(OSC, k2); bus_wr(OSC, v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < NREG; i++) flip[i] = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    for (int i = 0; i < NREG; i++) flip[i] = '0;
    one_way = 1'b0;
    do_reset();
    // R7 reset state
    chk(lock_o == 1'b0, "R7 lock after reset", int'(lock_o), 0);
    chk(mismatch_rst_o == 1'b0, "R7 req after reset", int'(mismatch_rst_o), 0);
    chk(regfile_we_o == '0, "R7 we after reset", int'(regfile_we_o), 0);

    // R2/R4: unlocked writes to every register, twice
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < NREG; i++) begin
        v = DW'(16'hA000 + pass * 16'h0100 + i * 17);
        bus_wr(BASE + i, int'(v));
        chk(we_snap == NREG'(1 << i), "R2 onehot enable", int'(we_snap), 1 << i);
        chk(live_q[i] == v, "R4 unlocked update", int'(live_q[i]), int'(v));
      end
    end
    for (int a = 1; a < BASE; a++) begin
      bus_wr(a, 16'h1234);
      chk(we_snap == '0, "R2 foreign address", int'(we_snap), 0);
    end
    // R9 no pulse after legal writes
    @(negedge clk);
    chk(mismatch_rst_o == 1'b0, "R9 no mismatch on legal write", int'(mismatch_rst_o), 0);
    @(negedge clk);
    chk(mismatch_rst_o == 1'b0, "R9 no mismatch on legal write", int'(mismatch_rst_o), 0);

    // R3: key writes and unkeyed writes leave lock alone
    bus_wr(OSC, 8'h46);
    chk(lock_o == 1'b0, "R3 key write no effect", int'(lock_o), 0);
    bus_wr(OSC, 8'h40);
    chk(lock_o == 1'b0, "R3 unkeyed write no effect", int'(lock_o), 0);
    key_seq(8'h46, 8'h57, 8'h40);
    chk(lock_o == 1'b1, "R3 keyed lock set", int'(lock_o), 1);

    // R1: locked writes blocked
    for (int i = 0; i < NREG; i++) begin
      v = live_q[i];
      bus_wr(BASE + i, 16'h5A5A);
      chk(we_snap == '0, "R1 locked enable", int'(we_snap), 0);
      chk(live_q[i] == v, "R1 locked contents", int'(live_q[i]), int'(v));
    end
    repeat (20) @(negedge clk);
    chk(lock_o == 1'b1, "R4 lock holds", int'(lock_o), 1);

    // R6: wrong first key sweep
    for (int k = 0; k < 256; k++) begin
      if (k != 8'h46) begin
        key_seq(k, 8'h57, 8'h00);
        chk(lock_o == 1'b1, "R6 wrong first key", int'(lock_o), 1);
      end
    end
    // R6: wrong second key sweep
    for (int k = 0; k < 256; k++) begin
      if (k != 8'h57) begin
        key_seq(8'h46, k, 8'h00);
        chk(lock_o == 1'b1, "R6 wrong second key", int'(lock_o), 1);
      end
    end
    // R6: intervening writes
    bus_wr(OSC, 8'h46); bus_wr(BASE + 1, 16'h0); bus_wr(OSC, 8'h57); bus_wr(OSC, 8'h00);
    chk(lock_o == 1'b1, "R6 write between keys", int'(lock_o), 1);
    bus_wr(OSC, 8'h46); bus_wr(OSC, 8'h57); bus_wr(2, 16'h0); bus_wr(OSC, 8'h00);
    chk(lock_o == 1'b1, "R6 write before update", int'(lock_o), 1);
    // R6: idle cycles between keys are fine
    bus_wr(OSC, 8'h46); repeat (5) @(negedge clk);
    bus_wr(OSC, 8'h57); repeat (5) @(negedge clk);
    bus_wr(OSC, 8'hBF);
    chk(lock_o == 1'b0, "R3 bit6 clear, idle gaps", int'(lock_o), 0);
    key_seq(8'h46, 8'h57, 8'h40);
    chk(lock_o == 1'b1, "R3 relock", int'(lock_o), 1);
    key_seq(8'h46, 8'h57, 8'h00);
    chk(lock_o == 1'b0, "R5 reclear without one-way", int'(lock_o), 0);

    // R5: one-way mode
    one_way = 1'b1;
    do_reset();
    chk(lock_o == 1'b0, "R7 lock after reset", int'(lock_o), 0);
    key_seq(8'h46, 8'h57, 8'h00);
    chk(lock_o == 1'b0, "R5 clear before set", int'(lock_o), 0);
    bus_wr(BASE + 3, 16'h0F0F);
    chk(we_snap == 4'b1000, "R5 writable before set", int'(we_snap), 8);
    key_seq(8'h46, 8'h57, 8'h40);
    chk(lock_o == 1'b1, "R5 one-way set", int'(lock_o), 1);
    key_seq(8'h46, 8'h57, 8'h00);
    chk(lock_o == 1'b1, "R5 one-way clear ignored", int'(lock_o), 1);
    bus_wr(BASE + 3, 16'hFFFF);
    chk(we_snap == '0, "R5 still blocked", int'(we_snap), 0);
    chk(live_q[3] == 16'h0F0F, "R5 contents kept", int'(live_q[3]), 16'h0F0F);
    do_reset();
    chk(lock_o == 1'b0, "R5 reset reopens", int'(lock_o), 0);
    bus_wr(BASE + 2, 16'h1111);
    chk(we_snap == 4'b0100, "R5 writable after reset", int'(we_snap), 4);

    // R8: flip every bit of every register
    for (int i = 0; i < NREG; i++) begin
      for (int b = 0; b < DW; b++) begin
        @(negedge clk);
        flip[i] = DW'(1) << b;
        @(negedge clk);
        chk(mismatch_rst_o == 1'b1, "R8 pulse on disturb", int'(mismatch_rst_o), 1);
        @(negedge clk);
        chk(mismatch_rst_o == 1'b0, "R8 pulse one cycle", int'(mismatch_rst_o), 0);
        flip[i] = '0;
        @(negedge clk);
      end
    end
    chk(mismatch_rst_o == 1'b0, "R8 quiet after restore", int'(mismatch_rst_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule